// File: doc/BRIEF.md
# Paged Circular-Buffer Address Generator

This block forms 24-bit data-memory addresses for indirect loads and stores. It keeps four 16-bit index pointers. Each pointer has its own modify, length and base register. One 8-bit page register supplies the upper address byte. A request names a pointer and chooses between two orderings. In pre-modify, the updated index is both used as the address and stored back. In post-modify, the address uses the current index and the updated index is then stored. The step comes from one of the four modify registers or from an 8-bit signed immediate.

When a pointer's length is zero, the index steps linearly modulo 2^16. When the length is nonzero, the updated index is folded back into the window base .. base+length-1. Neither mode ever carries into the page byte. A second full copy of all registers exists, and a select input chooses which copy is active, so a context switch costs no cycles. Registers are loaded through a small write port.

Top module: `dag_addr_gen`

## Requirements
- R1: After reset, addr_valid is low and every register in both banks is zero. A post-modify request with immediate 0 then returns address 0.
- R2: A post-modify request (req_pre=0) returns {page, current index} on addr_out.
- R3: A pre-modify request (req_pre=1) returns {page, updated index} on addr_out.
- R4: Every request writes the updated index back to the named pointer, so the next request on that pointer starts from it.
- R5: With req_use_imm=1, the step is req_imm read as an 8-bit two's-complement value and sign-extended to 16 bits.
- R6: With req_use_imm=0, the step is the modify register chosen by req_mod_sel, read as a 16-bit two's-complement value.
- R7: A length of zero gives linear stepping. The updated index is (index + step) mod 2^16, and the page byte is unchanged.
- R8: A nonzero length L with base B keeps an index inside B..B+L-1 (mod 2^16) by adding or subtracting L once, provided |step| < L.
- R9: addr_out[23:16] always equals the page register of the active bank. Wrapping never changes it.
- R10: bank_sel chooses the active register set (0 or 1). Register writes and index write-back touch only the active set, and the other set keeps its contents.
- R11: The write port selects a register with wr_kind (0 index, 1 modify, 2 length, 3 base, 4 page; 5 to 7 are ignored) and a pointer with wr_ptr. A write is visible to a request one clock later. On a same-cycle write to the index a request is updating, the write wins.
- R12: addr_valid is high in exactly the cycle after a cycle with req_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | Active register set |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Register kind: 0 index, 1 modify, 2 length, 3 base, 4 page |
| wr_ptr | input | 2 | Pointer number for the write |
| wr_data | input | 16 | Write value (page uses bits 7:0) |
| req_valid | input | 1 | Address request |
| req_ptr | input | 2 | Pointer used by the request |
| req_pre | input | 1 | 1 pre-modify, 0 post-modify |
| req_use_imm | input | 1 | 1 step from immediate, 0 from modify register |
| req_mod_sel | input | 2 | Modify register used as step |
| req_imm | input | 8 | Signed immediate step |
| addr_valid | output | 1 | Address valid |
| addr_out | output | 24 | Generated address |

## Verification
The address is registered, so the result of a request appears on addr_out in the cycle after the request is presented. The pointer write-back lands on the same edge. A register write lands on the edge that closes its cycle, so a request in the following cycle sees it. The bench drives every input on the falling edge. It reads addr_out on the next falling edge, which falls in the cycle after the capturing edge, and it leaves an idle cycle between operations so that each check sees exactly one edge's effect.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [2:0] {
    RK_INDEX  = 3'd0,
    RK_MODIFY = 3'd1,
    RK_LENGTH = 3'd2,
    RK_BASE   = 3'd3,
    RK_PAGE   = 3'd4
  } reg_kind_e;
endpackage

// File: rtl/dag_regfile.sv
module dag_regfile #(
  parameter int IDX_W = 16,
  parameter int PG_W  = 8,
  parameter int NPTR  = 4,
  parameter int NBANK = 2,
  localparam int PTR_W = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BSEL_W-1:0]      bank_sel,
  input  logic                   wr_en,
  input  dag_pkg::reg_kind_e     wr_kind,
  input  logic [PTR_W-1:0]       wr_ptr,
  input  logic [IDX_W-1:0]       wr_data,
  input  logic                   wb_en,
  input  logic [PTR_W-1:0]       wb_ptr,
  input  logic [IDX_W-1:0]       wb_data,
  output logic [IDX_W-1:0]       idx_o  [NPTR],
  output logic [IDX_W-1:0]       mod_o  [NPTR],
  output logic [IDX_W-1:0]       len_o  [NPTR],
  output logic [IDX_W-1:0]       base_o [NPTR],
  output logic [PG_W-1:0]        page_o
);
  import dag_pkg::*;

  logic [IDX_W-1:0] idx_q  [NBANK][NPTR];
  logic [IDX_W-1:0] idx_d  [NBANK][NPTR];
  logic [IDX_W-1:0] mod_q  [NBANK][NPTR];
  logic [IDX_W-1:0] mod_d  [NBANK][NPTR];
  logic [IDX_W-1:0] len_q  [NBANK][NPTR];
  logic [IDX_W-1:0] len_d  [NBANK][NPTR];
  logic [IDX_W-1:0] base_q [NBANK][NPTR];
  logic [IDX_W-1:0] base_d [NBANK][NPTR];
  logic [PG_W-1:0]  page_q [NBANK];
  logic [PG_W-1:0]  page_d [NBANK];

  always_comb begin
    idx_d  = idx_q;
    mod_d  = mod_q;
    len_d  = len_q;
    base_d = base_q;
    page_d = page_q;
    for (int b = 0; b < NBANK; b++) begin
      if (BSEL_W'(b) == bank_sel) begin
        if (wb_en) idx_d[b][wb_ptr] = wb_data;
        if (wr_en) begin
          case (wr_kind)
            RK_INDEX:  idx_d[b][wr_ptr]  = wr_data;
            RK_MODIFY: mod_d[b][wr_ptr]  = wr_data;
            RK_LENGTH: len_d[b][wr_ptr]  = wr_data;
            RK_BASE:   base_d[b][wr_ptr] = wr_data;
            RK_PAGE:   page_d[b]         = wr_data[PG_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        page_q[b] <= '0;
        for (int p = 0; p < NPTR; p++) begin
          idx_q[b][p]  <= '0;
          mod_q[b][p]  <= '0;
          len_q[b][p]  <= '0;
          base_q[b][p] <= '0;
        end
      end
    end else begin
      idx_q  <= idx_d;
      mod_q  <= mod_d;
      len_q  <= len_d;
      base_q <= base_d;
      page_q <= page_d;
    end
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_out
    assign idx_o[p]  = idx_q[bank_sel][p];
    assign mod_o[p]  = mod_q[bank_sel][p];
    assign len_o[p]  = len_q[bank_sel][p];
    assign base_o[p] = base_q[bank_sel][p];
  end
  assign page_o = page_q[bank_sel];

  // R10: the inactive bank's page never moves
  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    assert_idle_bank_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sel != BSEL_W'(b)) |=> (page_q[b] == $past(page_q[b])));
  end
endmodule

// File: rtl/dag_step.sv
module dag_step #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] step,
  input  logic [IDX_W-1:0] len,
  input  logic [IDX_W-1:0] base,
  output logic [IDX_W-1:0] nxt
);
  localparam int SW = IDX_W + 2;

  logic [IDX_W-1:0]    off;
  logic signed [SW-1:0] off_s, step_s, len_s, sum_s, adj_s;

  always_comb begin
    off    = idx - base;
    off_s  = {2'b00, off};
    step_s = {{2{step[IDX_W-1]}}, step};
    len_s  = {2'b00, len};
    sum_s  = off_s + step_s;
    if (sum_s < 0)           adj_s = sum_s + len_s;
    else if (sum_s >= len_s) adj_s = sum_s - len_s;
    else                     adj_s = sum_s;
    if (len == '0) nxt = idx + step;
    else           nxt = base + adj_s[IDX_W-1:0];
  end
endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen #(
  parameter int IDX_W = 16,
  parameter int PG_W  = 8,
  parameter int NPTR  = 4,
  parameter int IMM_W = 8,
  localparam int PTR_W = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int ADDR_W = PG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel,
  input  logic              wr_en,
  input  logic [2:0]        wr_kind,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [IDX_W-1:0]  wr_data,
  input  logic              req_valid,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic              req_pre,
  input  logic              req_use_imm,
  input  logic [PTR_W-1:0]  req_mod_sel,
  input  logic [IMM_W-1:0]  req_imm,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_out
);
  logic [IDX_W-1:0] idx_a  [NPTR];
  logic [IDX_W-1:0] mod_a  [NPTR];
  logic [IDX_W-1:0] len_a  [NPTR];
  logic [IDX_W-1:0] base_a [NPTR];
  logic [PG_W-1:0]  page;
  logic [IDX_W-1:0] cur_idx, cur_len, cur_base, step_val, step_mag, nxt_idx;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic             valid_d, valid_q;

  dag_regfile #(.IDX_W(IDX_W), .PG_W(PG_W), .NPTR(NPTR), .NBANK(2)) u_regs (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .wr_en(wr_en), .wr_kind(dag_pkg::reg_kind_e'(wr_kind)), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .wb_en(req_valid), .wb_ptr(req_ptr), .wb_data(nxt_idx),
    .idx_o(idx_a), .mod_o(mod_a), .len_o(len_a), .base_o(base_a), .page_o(page)
  );

  always_comb begin
    cur_idx  = idx_a[req_ptr];
    cur_len  = len_a[req_ptr];
    cur_base = base_a[req_ptr];
    step_val = req_use_imm ? {{(IDX_W-IMM_W){req_imm[IMM_W-1]}}, req_imm}
                           : mod_a[req_mod_sel];
    step_mag = step_val[IDX_W-1] ? (~step_val + 1'b1) : step_val;
  end

  dag_step #(.IDX_W(IDX_W)) u_step (
    .idx(cur_idx), .step(step_val), .len(cur_len), .base(cur_base), .nxt(nxt_idx)
  );

  always_comb begin
    valid_d = req_valid;
    addr_d  = addr_q;
    if (req_valid) addr_d = {page, (req_pre ? nxt_idx : cur_idx)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
    end
  end

  assign addr_valid = valid_q;
  assign addr_out   = addr_q;

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);
  assert_valid_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid);
  assert_post_uses_old_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_pre) |=> (addr_out[IDX_W-1:0] == $past(cur_idx)));
  assert_page_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (addr_out[ADDR_W-1:IDX_W] == $past(page)));
  assert_stays_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_len != '0 && (cur_idx - cur_base) < cur_len && step_mag < cur_len)
      |-> ((nxt_idx - cur_base) < cur_len));
  assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_len == '0) |-> ((nxt_idx - cur_idx) == step_val));
endmodule

// File: tb/dag_addr_gen_tb.sv
module dag_addr_gen_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic bank_sel, wr_en, req_valid, req_pre, req_use_imm;
  logic [2:0] wr_kind;
  logic [1:0] wr_ptr, req_ptr, req_mod_sel;
  logic [15:0] wr_data;
  logic [7:0] req_imm;
  logic addr_valid;
  logic [23:0] addr_out;

  int n_chk = 0, n_bad = 0;
  int bk = 0;
  int m_idx [2][4], m_mod [2][4], m_len [2][4], m_base [2][4], m_page [2];

  always #10 clk = ~clk;

  dag_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_ptr(wr_ptr), .wr_data(wr_data), .req_valid(req_valid), .req_ptr(req_ptr),
    .req_pre(req_pre), .req_use_imm(req_use_imm), .req_mod_sel(req_mod_sel),
    .req_imm(req_imm), .addr_valid(addr_valid), .addr_out(addr_out)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int step_model(int idx, int m, int len, int base);
    int r;
    if (len == 0) return (idx + m) & 'hFFFF;
    r = ((idx - base) & 'hFFFF) + m;
    if (r < 0) r += len;
    else if (r >= len) r -= len;
    return (base + r) & 'hFFFF;
  endfunction

  task automatic wr(int kind, int p, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind[2:0]; wr_ptr = p[1:0]; wr_data = data[15:0];
    @(negedge clk);
    wr_en = 1'b0;
    case (kind)
      0: m_idx[bk][p]  = data & 'hFFFF;
      1: m_mod[bk][p]  = data & 'hFFFF;
      2: m_len[bk][p]  = data & 'hFFFF;
      3: m_base[bk][p] = data & 'hFFFF;
      4: m_page[bk]    = data & 'hFF;
      default: ;
    endcase
  endtask

  task automatic req(int p, bit pre, bit ui, int ms, int imm, string tag);
    int mv, cur, nx, exp;
    cur = m_idx[bk][p];
    if (ui) mv = imm;
    else mv = (m_mod[bk][ms] >= 32768) ? m_mod[bk][ms] - 65536 : m_mod[bk][ms];
    nx = step_model(cur, mv, m_len[bk][p], m_base[bk][p]);
    exp = (m_page[bk] << 16) | (pre ? nx : cur);
    @(negedge clk);
    req_valid = 1'b1; req_ptr = p[1:0]; req_pre = pre; req_use_imm = ui;
    req_mod_sel = ms[1:0]; req_imm = imm[7:0];
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, int'(addr_valid), 1);
    check({tag, " addr"}, int'(addr_out), exp);
    m_idx[bk][p] = nx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      m_page[b] = 0;
      for (int p = 0; p < 4; p++) begin
        m_idx[b][p] = 0; m_mod[b][p] = 0; m_len[b][p] = 0; m_base[b][p] = 0;
      end
    end
    rst_n = 1'b0; bank_sel = 1'b0; wr_en = 1'b0; wr_kind = 3'd0; wr_ptr = 2'd0;
    wr_data = 16'd0; req_valid = 1'b0; req_ptr = 2'd0; req_pre = 1'b0;
    req_use_imm = 1'b0; req_mod_sel = 2'd0; req_imm = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid low after reset", int'(addr_valid), 0);
    check("R1 addr zero after reset", int'(addr_out), 0);
    for (int p = 0; p < 4; p++) req(p, 0, 1, 0, 0, "R1 zero regs");
    bank_sel = 1'b1; bk = 1;
    req(3, 1, 0, 2, 0, "R1 zero regs bank1");
    bank_sel = 1'b0; bk = 0;

    // R2 R3 R4 R5 R6: linear stepping, both orderings and both step sources
    wr(4, 0, 16'h00A5);
    for (int p = 0; p < 4; p++) begin
      wr(0, p, 16'h1000 * (p + 1) + p);
      wr(1, p, (p == 3) ? 16'hFFF0 : 16'h0011 * (p + 1));
    end
    for (int p = 0; p < 4; p++)
      for (int ms = 0; ms < 4; ms++) begin
        req(p, 0, 0, ms, 0, "R2 R4 R6 post reg");
        req(p, 1, 0, ms, 0, "R3 R4 R6 pre reg");
      end
    for (int imm = -128; imm < 128; imm += 17) begin
      req(1, imm[0], 1, 0, imm, "R5 imm sweep");
    end
    req(2, 1, 1, 0, -128, "R5 imm -128");
    req(2, 1, 1, 0, 127, "R5 imm 127");

    // R7: linear wrap mod 2^16 without touching the page
    wr(0, 0, 16'hFFFE);
    req(0, 1, 1, 0, 3, "R7 R9 up across 0xFFFF");
    req(0, 0, 1, 0, -2, "R7 down across 0");
    req(0, 0, 1, 0, 0, "R7 R4 readback");

    // R8 R9 R11: circular sweep over lengths, starts, steps, orderings
    wr(4, 0, 16'h003C);
    for (int L = 1; L <= 6; L++) begin
      for (int bsel = 0; bsel < 2; bsel++) begin
        int base;
        base = bsel ? 16'hFFFD : 16'h0123;
        wr(2, 1, L);
        wr(3, 1, base);
        for (int s = 0; s < L; s++)
          for (int imm = -(L - 1); imm <= L - 1; imm++)
            for (int pre = 0; pre < 2; pre++) begin
              wr(0, 1, (base + s) & 'hFFFF);
              req(1, pre[0], 1, 0, imm, "R8 R9 R11 circular");
            end
      end
    end
    wr(2, 2, 8); wr(3, 2, 16'h0400); wr(0, 2, 16'h0406); wr(1, 3, 3);
    req(2, 1, 0, 3, 0, "R8 R6 circular reg step");
    req(2, 0, 0, 3, 0, "R8 circular reg step post");
    wr(5, 2, 16'h7777);
    req(2, 0, 1, 0, 0, "R11 reserved kind ignored");

    // R10: second bank is independent
    bank_sel = 1'b1; bk = 1;
    wr(4, 0, 16'h00E1); wr(0, 2, 16'h2222); wr(1, 0, 16'h0005);
    req(2, 1, 0, 0, 0, "R10 bank1 pre");
    req(2, 0, 1, 0, 0, "R10 bank1 readback");
    bank_sel = 1'b0; bk = 0;
    req(2, 0, 1, 0, 0, "R10 bank0 untouched");

    // R11: same-cycle write to the index being updated; the write wins
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 3'd0; wr_ptr = 2'd2; wr_data = 16'h0500;
    req_valid = 1'b1; req_ptr = 2'd2; req_pre = 1'b0; req_use_imm = 1'b1; req_imm = 8'd3;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R11 collide addr old index", int'(addr_out), (m_page[0] << 16) | m_idx[0][2]);
    m_idx[0][2] = 16'h0500;
    req(2, 0, 1, 0, 0, "R11 write wins");

    // R12: valid only in the cycle after a request
    @(negedge clk);
    check("R12 valid drops", int'(addr_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule